// File: doc/BRIEF.md
# Digital I/O Multi-Source Interrupt Controller

This block watches a bank of digital input ports and combines several kinds of event onto one level-sensitive interrupt request. Each port group has one source taken from its C port: a two-bit selector picks bit 0, bit 4, or either of the two. A polarity bit chooses whether a rising or a falling transition counts. Port group 0 has two more sources. The first is a pattern detector on port A0 that fires when every channel enabled by a mask equals a programmed pattern. The second is a change detector on port B0 that fires when any channel enabled by a mask toggles. With the default four groups there are six sources in all.

Every source latches its event into a sticky flag. Software reads the flag through a small register bus and clears it by writing 1 to the flag position. While a flag is set, further events from the same source change nothing. The pins are asynchronous and pass through a synchronizer before any detection. Software reaches the block through a write port and a combinational read port.

Top module: `dio_irq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0 and every register address reads 0.
- R2: Register map: addresses 0..NUM_GRP-1 hold the group controls, with D7 the C flag, D6 the polarity and D5:D4 the source selector. In group 0 only, D3 is the change flag, D2 the change enable, D1 the match flag and D0 the match enable; in the other groups D3:D0 read 0. Address NUM_GRP holds the match pattern, NUM_GRP+1 the match channel mask and NUM_GRP+2 the change channel mask. All other addresses read 0.
- R3: The source selector values are 00 = none, 01 = C bit 0, 10 = C bit 4, 11 = the OR of C bits 0 and 4. A transition on an unselected bit never sets the C flag.
- R4: With polarity 0 a 0-to-1 transition of the selected signal sets the C flag. With polarity 1 a 1-to-0 transition sets it.
- R5: The match flag sets only when the match enable is 1 and the masked A0 channels go from not all equal to all equal to the pattern. Channels outside the mask are ignored, and a match that continues does not set the flag again.
- R6: The change flag sets only when the change enable is 1 and a channel of B0 that is in the change mask differs from its previous sample. Channels outside the mask are ignored.
- R7: A flag stays set until a write of 1 to its bit position clears it. Writing 0 to that position leaves it set.
- R8: If an event from a source and a clear of its flag take effect on the same clock edge, the flag ends up set.
- R9: `irq_o` is the OR of the C flags of groups whose selector is not 00, the change flag if its enable is 1, and the match flag if its enable is 1. Disabling a source drops its part of `irq_o` but keeps the flag.
- R10: A pin change that was stable before a clock edge shows in the flag, and in `irq_o`, after the third clock edge and not after the second (two synchronizer stages plus the flag register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | AW | Read address |
| rd_data_o | output | 8 | Read data, combinational from rd_addr_i |
| pa_i | input | 8 | Port A0 pins, asynchronous |
| pb_i | input | 8 | Port B0 pins, asynchronous |
| pc_i | input | 8*NUM_GRP | C ports of all groups, group g in bits 8g+7:8g |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench sweeps every selector value, polarity, selected bit and transition direction on every group. A design with a swapped selector or polarity would flag the wrong bit or the wrong edge, and one that used the enable for the previous sample would fire spuriously when the mode is written. All 256 A0 values go through the pattern detector in order. A level-triggered detector would set the flag again on every step that keeps matching, and a design without masking would react to channels outside the mask. Around the change detector and the flag logic, the bench aims an event at the exact edge where a clear lands, checks that a write of 0 cannot clear a flag, and checks that disabling a source drops the request but keeps the flag. It also pins down the third-edge latency, which an extra or a missing register stage would move.

// File: rtl/dio_irq_pkg.sv
`timescale 1ns/1ps
package dio_irq_pkg;

    localparam int PORT_W = 8;
    localparam int REG_W  = 8;

    // selector for the port-C source of one group
    typedef enum logic [1:0] {
        SRC_OFF    = 2'b00,
        SRC_BIT0   = 2'b01,
        SRC_BIT4   = 2'b10,
        SRC_EITHER = 2'b11
    } csrc_e;

    typedef struct packed {
        logic  flag;
        logic  fall;
        csrc_e mode;
    } grp_ctl_t;

    // control register bit positions
    localparam int B_CFLAG    = 7;
    localparam int B_FALL     = 6;
    localparam int B_MODE_LO  = 4;
    localparam int B_COS_FLAG = 3;
    localparam int B_COS_EN   = 2;
    localparam int B_PM_FLAG  = 1;
    localparam int B_PM_EN    = 0;

    // port-C bits that the selector can pick
    localparam int SEL_LO = 0;
    localparam int SEL_HI = 4;

endpackage

// File: rtl/dio_sync.sv
`timescale 1ns/1ps
module dio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dio_portc_src.sv
`timescale 1ns/1ps
module dio_portc_src
    import dio_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] c_i,
    input  csrc_e             mode_i,
    input  logic              fall_i,
    output logic              evt_o
);
    logic [PORT_W-1:0] prev_d, prev_q;
    logic              cur_s, old_s;

    function automatic logic pick(input logic [PORT_W-1:0] v, input csrc_e m);
        case (m)
            SRC_BIT0:   return v[SEL_LO];
            SRC_BIT4:   return v[SEL_HI];
            SRC_EITHER: return v[SEL_LO] | v[SEL_HI];
            default:    return 1'b0;
        endcase
    endfunction

    always_comb begin
        prev_d = c_i;
        cur_s  = pick(c_i, mode_i);
        old_s  = pick(prev_q, mode_i);
        evt_o  = (mode_i != SRC_OFF) &&
                 (fall_i ? (old_s && !cur_s) : (!old_s && cur_s));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    // R3
    off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == SRC_OFF) |-> !evt_o);

    // R3
    static_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (c_i == prev_q) |-> !evt_o);
endmodule

// File: rtl/dio_pattern_det.sv
`timescale 1ns/1ps
module dio_pattern_det
    import dio_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] val_i,
    input  logic [PORT_W-1:0] pat_i,
    input  logic [PORT_W-1:0] mask_i,
    output logic              evt_o
);
    logic match, match_d, match_q;

    always_comb begin
        match   = ((val_i ^ pat_i) & mask_i) == '0;
        match_d = match;
        evt_o   = match && !match_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) match_q <= 1'b1;
        else         match_q <= match_d;
    end

    // R5
    one_shot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_o |=> !evt_o);
endmodule

// File: rtl/dio_cos_det.sv
`timescale 1ns/1ps
module dio_cos_det
    import dio_irq_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [PORT_W-1:0] val_i,
    input  logic [PORT_W-1:0] mask_i,
    output logic              evt_o
);
    logic [PORT_W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = val_i;
        evt_o  = |((val_i ^ prev_q) & mask_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= prev_d;
    end

    // R6
    no_mask_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_i == '0) |-> !evt_o);
endmodule

// File: rtl/dio_irq_ctrl.sv
`timescale 1ns/1ps
module dio_irq_ctrl
    import dio_irq_pkg::*;
#(
    parameter int NUM_GRP     = 4,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(NUM_GRP + 3)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic                      wr_en_i,
    input  logic [AW-1:0]             wr_addr_i,
    input  logic [REG_W-1:0]          wr_data_i,
    input  logic [AW-1:0]             rd_addr_i,
    output logic [REG_W-1:0]          rd_data_o,
    input  logic [PORT_W-1:0]         pa_i,
    input  logic [PORT_W-1:0]         pb_i,
    input  logic [NUM_GRP*PORT_W-1:0] pc_i,
    output logic                      irq_o
);
    localparam int IN_W   = (NUM_GRP + 2) * PORT_W;
    localparam int A_PAT  = NUM_GRP;
    localparam int A_PMSK = NUM_GRP + 1;
    localparam int A_CMSK = NUM_GRP + 2;

    typedef struct packed {
        grp_ctl_t [NUM_GRP-1:0] grp;
        logic                   pm_en;
        logic                   pm_flag;
        logic                   cos_en;
        logic                   cos_flag;
        logic [PORT_W-1:0]      pat;
        logic [PORT_W-1:0]      pat_mask;
        logic [PORT_W-1:0]      cos_mask;
    } st_t;

    st_t st_d, st_q;

    // ---------------- input synchronization ----------------
    logic [IN_W-1:0]           pins_s;
    logic [PORT_W-1:0]         pa_s, pb_s;
    logic [NUM_GRP*PORT_W-1:0] pc_s;

    dio_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    ({pc_i, pb_i, pa_i}),
        .q_o    (pins_s)
    );

    assign pa_s = pins_s[PORT_W-1:0];
    assign pb_s = pins_s[2*PORT_W-1:PORT_W];
    assign pc_s = pins_s[IN_W-1:2*PORT_W];

    // ---------------- event detectors ----------------
    logic [NUM_GRP-1:0] c_evt;
    logic               pm_evt, cos_evt;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_csrc
        dio_portc_src u_src (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .c_i    (pc_s[g*PORT_W +: PORT_W]),
            .mode_i (st_q.grp[g].mode),
            .fall_i (st_q.grp[g].fall),
            .evt_o  (c_evt[g])
        );
    end

    dio_pattern_det u_pm (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .val_i  (pa_s),
        .pat_i  (st_q.pat),
        .mask_i (st_q.pat_mask),
        .evt_o  (pm_evt)
    );

    dio_cos_det u_cos (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .val_i  (pb_s),
        .mask_i (st_q.cos_mask),
        .evt_o  (cos_evt)
    );

    // ---------------- register and flag update ----------------
    logic [NUM_GRP-1:0] wr_grp;

    always_comb begin
        st_d = st_q;
        for (int g = 0; g < NUM_GRP; g++) begin
            wr_grp[g] = wr_en_i && (wr_addr_i == AW'(g));
        end

        for (int g = 0; g < NUM_GRP; g++) begin
            if (wr_grp[g]) begin
                st_d.grp[g].fall = wr_data_i[B_FALL];
                st_d.grp[g].mode = csrc_e'(wr_data_i[B_MODE_LO +: 2]);
                if (wr_data_i[B_CFLAG]) st_d.grp[g].flag = 1'b0;
            end
            // a new event wins over a clear on the same edge
            if (c_evt[g]) st_d.grp[g].flag = 1'b1;
        end

        if (wr_grp[0]) begin
            st_d.cos_en = wr_data_i[B_COS_EN];
            st_d.pm_en  = wr_data_i[B_PM_EN];
            if (wr_data_i[B_COS_FLAG]) st_d.cos_flag = 1'b0;
            if (wr_data_i[B_PM_FLAG])  st_d.pm_flag  = 1'b0;
        end
        if (cos_evt && st_q.cos_en) st_d.cos_flag = 1'b1;
        if (pm_evt  && st_q.pm_en)  st_d.pm_flag  = 1'b1;

        if (wr_en_i) begin
            if (wr_addr_i == AW'(A_PAT))  st_d.pat      = wr_data_i[PORT_W-1:0];
            if (wr_addr_i == AW'(A_PMSK)) st_d.pat_mask = wr_data_i[PORT_W-1:0];
            if (wr_addr_i == AW'(A_CMSK)) st_d.cos_mask = wr_data_i[PORT_W-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // ---------------- read port ----------------
    always_comb begin
        rd_data_o = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (rd_addr_i == AW'(g)) begin
                rd_data_o[B_CFLAG]        = st_q.grp[g].flag;
                rd_data_o[B_FALL]         = st_q.grp[g].fall;
                rd_data_o[B_MODE_LO +: 2] = st_q.grp[g].mode;
                if (g == 0) begin
                    rd_data_o[B_COS_FLAG] = st_q.cos_flag;
                    rd_data_o[B_COS_EN]   = st_q.cos_en;
                    rd_data_o[B_PM_FLAG]  = st_q.pm_flag;
                    rd_data_o[B_PM_EN]    = st_q.pm_en;
                end
            end
        end
        if (rd_addr_i == AW'(A_PAT))  rd_data_o = REG_W'(st_q.pat);
        if (rd_addr_i == AW'(A_PMSK)) rd_data_o = REG_W'(st_q.pat_mask);
        if (rd_addr_i == AW'(A_CMSK)) rd_data_o = REG_W'(st_q.cos_mask);
    end

    // ---------------- interrupt request ----------------
    logic any_flag;

    always_comb begin
        irq_o    = (st_q.cos_flag && st_q.cos_en) || (st_q.pm_flag && st_q.pm_en);
        any_flag = st_q.cos_flag || st_q.pm_flag;
        for (int g = 0; g < NUM_GRP; g++) begin
            irq_o    = irq_o || (st_q.grp[g].flag && (st_q.grp[g].mode != SRC_OFF));
            any_flag = any_flag || st_q.grp[g].flag;
        end
    end

    // R9
    irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> any_flag);

    // R8
    cos_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cos_evt && st_q.cos_en) |=> st_q.cos_flag);

    // R7
    cos_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cos_flag && !(wr_grp[0] && wr_data_i[B_COS_FLAG])) |=> st_q.cos_flag);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_chk
        // R8
        c_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            c_evt[g] |=> st_q.grp[g].flag);

        // R7
        c_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (st_q.grp[g].flag && !(wr_grp[g] && wr_data_i[B_CFLAG])) |=> st_q.grp[g].flag);
    end
endmodule

// File: tb/sim_dio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dio_irq_ctrl;
    localparam int NG = 4;
    localparam int AW = 3;
    localparam logic [AW-1:0] A_PAT  = 3'd4;
    localparam logic [AW-1:0] A_PMSK = 3'd5;
    localparam logic [AW-1:0] A_CMSK = 3'd6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic [7:0]    pa = '0, pb = '0;
    logic [NG*8-1:0] pc = '0;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dio_irq_ctrl #(.NUM_GRP(NG)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .pa_i(pa), .pb_i(pb), .pc_i(pc), .irq_o(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait3();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    function automatic bit pm_match(input logic [7:0] v);
        return ((v ^ 8'h82) & 8'hC6) == 8'h00;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit prev_m;
        logic [7:0] prev_b;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), d);
            chk("R1 reg", d, 0);
        end

        // R2: register layout
        wr(3'd1, 8'h7F);
        rd(3'd1, d); chk("R2 grp1 layout", d, 8'h70);
        wr(3'd0, 8'h75);
        rd(3'd0, d); chk("R2 grp0 layout", d, 8'h75);
        wr(A_PAT, 8'hA5);  rd(A_PAT, d);  chk("R2 pattern", d, 8'hA5);
        wr(A_PMSK, 8'h3C); rd(A_PMSK, d); chk("R2 pm mask", d, 8'h3C);
        wr(A_CMSK, 8'h81); rd(A_CMSK, d); chk("R2 cos mask", d, 8'h81);
        rd(3'd7, d); chk("R2 unused", d, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(A_PAT, 8'h00); wr(A_PMSK, 8'h00); wr(A_CMSK, 8'h00);

        // R3 / R4: port-C source sweep
        for (int g = 0; g < NG; g++) begin
            for (int m = 0; m < 4; m++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int bi = 0; bi < 2; bi++) begin
                        for (int dir = 0; dir < 2; dir++) begin
                            int  b;
                            bit  sel, fire;
                            b = bi ? 4 : 0;
                            wr(AW'(g), 8'h80);
                            pc[g*8+b] = (dir == 0);
                            settle();
                            wr(AW'(g), {1'b1, e[0], m[1:0], 4'b0000});
                            pc[g*8+b] = (dir == 1);
                            wait3();
                            sel  = (m == 1 && b == 0) || (m == 2 && b == 4) || (m == 3);
                            fire = sel && ((e == 1) ? (dir == 0) : (dir == 1));
                            rd(AW'(g), d);
                            chk(e ? "R4 falling flag" : "R3 rising flag", d[7], fire);
                            chk("R9 irq from C", irq, fire);
                            wr(AW'(g), 8'h80);
                            pc[g*8+b] = 1'b0;
                            settle();
                            wr(AW'(g), 8'h80);
                        end
                    end
                end
            end
        end

        // R5: pattern match, all A0 values in order
        wr(A_PMSK, 8'hC6);
        wr(A_PAT, 8'h82);
        wr(3'd0, 8'h03);
        pa = 8'h00;
        settle();
        wr(3'd0, 8'h03);
        prev_m = pm_match(8'h00);
        for (int v = 0; v < 256; v++) begin
            bit exp;
            pa = 8'(v);
            wait3();
            exp = pm_match(8'(v)) && !prev_m;
            rd(3'd0, d);
            chk("R5 match flag", d[1], exp);
            chk("R9 irq from match", irq, exp);
            wr(3'd0, 8'h03);
            prev_m = pm_match(8'(v));
        end
        // R5: disabled source does not set
        wr(3'd0, 8'h02);
        pa = 8'h00; settle();
        pa = 8'h82; wait3();
        rd(3'd0, d);
        chk("R5 disabled match", d[1], 0);
        chk("R5 disabled irq", irq, 0);

        // R6: change of state
        wr(A_CMSK, 8'h5A);
        wr(3'd0, 8'h0C);
        prev_b = pb;
        for (int i = 1; i <= 64; i++) begin
            logic [7:0] v;
            bit exp;
            v = 8'(i * 37);
            pb = v;
            wait3();
            exp = ((v ^ prev_b) & 8'h5A) != 0;
            rd(3'd0, d);
            chk("R6 change flag", d[3], exp);
            wr(3'd0, 8'h0C);
            prev_b = v;
        end
        pb = prev_b ^ 8'hA5;
        wait3();
        rd(3'd0, d); chk("R6 unmasked only", d[3], 0);

        // R10: latency
        pb = pb ^ 8'h02;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd(3'd0, d); chk("R10 not after 2 edges", d[3], 0);
        chk("R10 irq not after 2 edges", irq, 0);
        @(posedge clk); @(negedge clk);
        rd(3'd0, d); chk("R10 set after 3 edges", d[3], 1);
        chk("R10 irq after 3 edges", irq, 1);

        // R7: write 0 keeps, write 1 clears
        wr(3'd0, 8'h04);
        rd(3'd0, d); chk("R7 write0 keeps", d[3], 1);
        wr(3'd0, 8'h0C);
        rd(3'd0, d); chk("R7 write1 clears", d[3], 0);

        // R8: event and clear on the same edge
        pb = pb ^ 8'h08;
        wait3();
        pb = pb ^ 8'h08;
        repeat (2) @(posedge clk);
        wr(3'd0, 8'h0C);
        rd(3'd0, d); chk("R8 set wins", d[3], 1);
        wr(3'd0, 8'h0C);
        rd(3'd0, d); chk("R8 plain clear", d[3], 0);

        // R9: disabling keeps flag, drops irq
        pb = pb ^ 8'h10;
        wait3();
        chk("R9 irq on", irq, 1);
        wr(3'd0, 8'h00);
        rd(3'd0, d);
        chk("R9 flag kept", d[3], 1);
        chk("R9 irq masked", irq, 0);
        wr(3'd0, 8'h04);
        chk("R9 irq back", irq, 1);
        wr(3'd0, 8'h08);
        chk("R9 irq cleared", irq, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule